// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits between the bit-level deframer of an HDLC receiver and its receive FIFO. It watches the byte stream of each frame, reads the address field at its head, and decides whether the frame is for this station. Accepted frames pass through unchanged, with their start and end markers intact. Rejected frames are removed whole, so the FIFO never sees a byte of them.

The least significant bit of the first received byte is the address extension flag. When it is 1, the address is one byte long and the second byte is ordinary frame content. When it is 0, the address spans two bytes. Two programmable address words set the expected values. In each word, bit 0 switches the comparison for that byte on. An all-call address is one whose compared bits are all ones, and it is accepted regardless of the programmed values. A seven-bit option widens the single-byte comparison. With filtering switched off, every frame passes.

The first byte of each frame is held back until the decision can be made. In two-byte mode that means until the second byte arrives. After the decision, bytes flow through one slot behind the input. For each frame, one decision strobe is raised alongside the first byte's output slot.

Top module: `hdlc_addr_filter`

## Requirements
- R1: With `cfg_filter_en` low, every frame is accepted. Each of its bytes appears on the output in order, with the same data and the same start and end flags.
- R2: Bit 0 of each address word enables the comparison for the matching address byte. A byte whose enable is 0 always counts as matching.
- R3: When bit 0 of the first byte is 0, the frame has a two-byte address. Bits 7:2 of the first byte are compared with bits 7:2 of `cfg_addr0`, and bits 7:1 of the second byte with bits 7:1 of `cfg_addr1`. The frame is accepted only if every enabled byte matches.
- R4: With a two-byte address, a second byte whose bits 7:1 are all ones is an all-call. The frame is then accepted whatever the first byte and both address words hold.
- R5: When bit 0 of the first byte is 1, the frame has a one-byte address. It is accepted if the compared bits of that byte are all ones, or if they match `cfg_addr0` (or that byte's compare is disabled). The second byte and `cfg_addr1` play no part.
- R6: `cfg_seven_bit` high makes the one-byte compare and the one-byte all-call test use bits 7:1 instead of bits 7:2. Two-byte mode is not affected.
- R7: A rejected frame produces no output byte. Nothing is output until the next start-of-frame. An accepted frame outputs all of its bytes.
- R8: A byte leaves the output one cycle after the next input byte is taken. The last byte of a frame leaves one cycle after it is taken itself.
- R9: Each frame raises `dec_valid` for exactly one cycle, in the same cycle as its first byte's output slot. `dec_accept` gives the verdict in that cycle.
- R10: A frame whose first byte has bit 0 equal to 0 but which ends on that byte is rejected while filtering is on.
- R11: After reset, `out_valid` and `dec_valid` are low until frames are fed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_filter_en | input | 1 | Address filtering on |
| cfg_seven_bit | input | 1 | Seven-bit compare for one-byte addresses |
| cfg_addr0 | input | 8 | First address word; bit 0 enables its compare |
| cfg_addr1 | input | 8 | Second address word; bit 0 enables its compare |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid (FIFO write strobe) |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| dec_valid | output | 1 | Frame decision strobe |
| dec_accept | output | 1 | Frame verdict, valid with `dec_valid` |

## Verification
The assertions check, on every cycle, the invariants that tie the output to the decision. A rejected verdict never comes with an output byte. Every emitted first byte carries an accepting strobe. A frame in the dropped state emits nothing. Verdicts with filtering off or with a two-byte all-call are always accepts, and the hold slot empties after a frame's last byte. Whether a verdict is correct for each combination of extension bit, per-byte enables, seven-bit mode and address value can only be shown by the bench's sweeps over the first byte, and the same holds for the exact cycle in which each byte emerges.

// File: rtl/haf_pkg.sv
package haf_pkg;
  // Bit that carries both the received extension flag and the per-word enable
  localparam int unsigned HAF_FLAG_BIT = 0;

  typedef enum logic [1:0] {
    ADDR_ONE   = 2'd0,
    ADDR_TWO   = 2'd1,
    ADDR_SHORT = 2'd2
  } addr_mode_e;
endpackage

// File: rtl/haf_hold.sv
module haf_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          hold_v,
  output logic [DW-1:0] hold_d,
  output logic          hold_sof,
  output logic          hold_eof,
  output logic          drain
);
  // The held byte leaves when a successor arrives or when it closes its frame
  assign drain = hold_v && (in_valid || hold_eof);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v   <= 1'b0;
      hold_sof <= 1'b0;
      hold_eof <= 1'b0;
    end else if (in_valid) begin
      hold_v   <= 1'b1;
      hold_sof <= in_sof;
      hold_eof <= in_eof;
    end else if (drain) begin
      hold_v   <= 1'b0;
      hold_sof <= 1'b0;
      hold_eof <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) hold_d <= in_data;
  end

  // A frame's closing byte never lingers once it has been released
  assert_hold_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_v && hold_eof && !in_valid) |=> !hold_v);
endmodule

// File: rtl/haf_decide.sv
module haf_decide
  import haf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          cfg_en,
  input  logic          cfg_seven,
  input  logic [DW-1:0] reg0,
  input  logic [DW-1:0] reg1,
  input  logic [DW-1:0] b0,
  input  logic [DW-1:0] b1,
  input  logic          b1_present,
  output logic          accept
);
  localparam int unsigned W7 = DW - 1;
  localparam int unsigned W6 = DW - 2;

  addr_mode_e mode;
  logic       en0, en1;
  logic       all7_b0, all6_b0, all_b1;
  logic       eq7_b0, eq6_b0, eq_b1;
  logic       one_ok, two_ok;

  assign en0 = reg0[HAF_FLAG_BIT];
  assign en1 = reg1[HAF_FLAG_BIT];

  assign all7_b0 = (b0[DW-1:1] == {W7{1'b1}});
  assign all6_b0 = (b0[DW-1:2] == {W6{1'b1}});
  assign all_b1  = (b1[DW-1:1] == {W7{1'b1}});
  assign eq7_b0  = (b0[DW-1:1] == reg0[DW-1:1]);
  assign eq6_b0  = (b0[DW-1:2] == reg0[DW-1:2]);
  assign eq_b1   = (b1[DW-1:1] == reg1[DW-1:1]);

  always_comb begin
    if (b0[HAF_FLAG_BIT])  mode = ADDR_ONE;
    else if (b1_present)   mode = ADDR_TWO;
    else                   mode = ADDR_SHORT;
  end

  always_comb begin
    if (cfg_seven) one_ok = all7_b0 || !en0 || eq7_b0;
    else           one_ok = all6_b0 || !en0 || eq6_b0;
    two_ok = all_b1 || ((!en0 || eq6_b0) && (!en1 || eq_b1));
  end

  always_comb begin
    if (!cfg_en) accept = 1'b1;
    else begin
      case (mode)
        ADDR_ONE: accept = one_ok;
        ADDR_TWO: accept = two_ok;
        default:  accept = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/haf_emit.sv
module haf_emit #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drain,
  input  logic [DW-1:0] hold_d,
  input  logic          hold_sof,
  input  logic          hold_eof,
  input  logic          accept,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic          dec_valid,
  output logic          dec_accept,
  output logic          pass
);
  logic keep;
  logic first;

  assign first = drain && hold_sof;
  assign keep  = hold_sof ? accept : pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      pass       <= 1'b0;
    end else begin
      out_valid <= drain && keep;
      dec_valid <= first;
      if (first) begin
        dec_accept <= accept;
        pass       <= accept;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (drain) begin
      out_data <= hold_d;
      out_sof  <= hold_sof;
      out_eof  <= hold_eof;
    end
  end

  // Body bytes only leave while the current frame is in the accepted state
  assert_body_needs_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> pass);
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_filter_en,
  input  logic          cfg_seven_bit,
  input  logic [DW-1:0] cfg_addr0,
  input  logic [DW-1:0] cfg_addr1,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic          dec_valid,
  output logic          dec_accept
);
  logic          hold_v, hold_sof, hold_eof, drain;
  logic [DW-1:0] hold_d;
  logic          accept, pass, b1_present;

  haf_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .hold_v(hold_v), .hold_d(hold_d), .hold_sof(hold_sof), .hold_eof(hold_eof),
    .drain(drain)
  );

  // The second address byte exists only if the held first byte did not end
  // the frame and the incoming byte belongs to the same frame
  assign b1_present = !hold_eof && !in_sof;

  haf_decide #(.DW(DW)) u_decide (
    .cfg_en(cfg_filter_en), .cfg_seven(cfg_seven_bit),
    .reg0(cfg_addr0), .reg1(cfg_addr1),
    .b0(hold_d), .b1(in_data), .b1_present(b1_present),
    .accept(accept)
  );

  haf_emit #(.DW(DW)) u_emit (
    .clk(clk), .rst(rst),
    .drain(drain), .hold_d(hold_d), .hold_sof(hold_sof), .hold_eof(hold_eof),
    .accept(accept),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .pass(pass)
  );

  assert_off_accepts_R1: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !$past(cfg_filter_en)) |-> dec_accept);

  assert_reject_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_accept) |-> !out_valid);

  assert_first_has_verdict_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> (dec_valid && dec_accept));

  assert_allcall_two_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(cfg_filter_en && hold_v && hold_sof && !hold_eof &&
                        !hold_d[0] && in_valid && !in_sof &&
                        (in_data[DW-1:1] == {(DW-1){1'b1}}))) |-> dec_accept);

  assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !dec_valid));
endmodule

// File: tb/hdlc_addr_filter_tb.sv
`timescale 1ns/1ps
module hdlc_addr_filter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_filter_en = 1'b0, cfg_seven_bit = 1'b0;
  logic [7:0] cfg_addr0 = 8'h00, cfg_addr1 = 8'h00;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, out_sof, out_eof, dec_valid, dec_accept;
  logic [7:0] out_data;

  int checks = 0, fails = 0;
  int n_out = 0, n_dec = 0;
  logic       last_acc = 1'b0;
  logic [7:0] got_d [8];
  logic       got_s [8];
  logic       got_e [8];

  always #4 clk = ~clk;

  hdlc_addr_filter u_dut (
    .clk(clk), .rst(rst),
    .cfg_filter_en(cfg_filter_en), .cfg_seven_bit(cfg_seven_bit),
    .cfg_addr0(cfg_addr0), .cfg_addr1(cfg_addr1),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (n_out < 8) begin
          got_d[n_out] = out_data;
          got_s[n_out] = out_sof;
          got_e[n_out] = out_eof;
        end
        n_out = n_out + 1;
      end
      if (dec_valid) begin
        n_dec = n_dec + 1;
        last_acc = dec_accept;
      end
    end
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // Verdict computed from the requirements
  function automatic bit expect_acc(input logic [7:0] b0, input logic [7:0] b1, input int len);
    int a0, a1, r0, r1;
    bit en0, en1;
    a0 = int'(b0); a1 = int'(b1); r0 = int'(cfg_addr0); r1 = int'(cfg_addr1);
    en0 = cfg_addr0[0]; en1 = cfg_addr1[0];
    if (!cfg_filter_en) return 1'b1;
    if (b0[0]) begin
      if (cfg_seven_bit) return ((a0 / 2) == 127) || !en0 || ((a0 / 2) == (r0 / 2));
      return ((a0 / 4) == 63) || !en0 || ((a0 / 4) == (r0 / 4));
    end
    if (len < 2) return 1'b0;
    if ((a1 / 2) == 127) return 1'b1;
    return (!en0 || ((a0 / 4) == (r0 / 4))) && (!en1 || ((a1 / 2) == (r1 / 2)));
  endfunction

  function automatic string tag_of(input logic [7:0] b0, input logic [7:0] b1, input int len);
    string t;
    if (!cfg_filter_en) t = "R1";
    else if (b0[0]) t = cfg_seven_bit ? "R6 R5" : "R5";
    else if (len < 2) t = "R10";
    else if (b1[7:1] == 7'h7F) t = "R4";
    else t = "R3";
    if (cfg_filter_en && (!cfg_addr0[0] || !cfg_addr1[0])) t = {t, " R2"};
    return t;
  endfunction

  task automatic run_frame(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input int len);
    logic [7:0] bytes [3];
    bit acc;
    string t;
    int exp_n;
    bit same;
    bytes[0] = a; bytes[1] = b; bytes[2] = c;
    acc = expect_acc(a, b, len);
    t = tag_of(a, b, len);
    @(negedge clk);
    n_out = 0; n_dec = 0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = bytes[i]; in_sof = (i == 0); in_eof = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_dec == 1 && last_acc == acc,
        $sformatf("R9 %s b0=%02h b1=%02h: actual dec=%0d acc=%0b expected dec=1 acc=%0b",
                  t, a, b, n_dec, last_acc, acc));
    exp_n = acc ? len : 0;
    chk(n_out == exp_n,
        $sformatf("R7 %s b0=%02h b1=%02h: actual bytes=%0d expected %0d", t, a, b, n_out, exp_n));
    if (acc && n_out == len) begin
      same = 1'b1;
      for (int i = 0; i < len; i++)
        if (got_d[i] != bytes[i] || got_s[i] != (i == 0) || got_e[i] != (i == len - 1)) same = 1'b0;
      chk(same, $sformatf("R1 R7 %s b0=%02h: actual first=%02h expected %02h", t, a, got_d[0], a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: quiet after reset
    chk(!out_valid && !dec_valid,
        $sformatf("R11 reset: actual out_valid=%0b dec_valid=%0b expected 0 0", out_valid, dec_valid));

    // R8: exact cycle of each byte, filtering off
    cfg_filter_en = 1'b0;
    @(negedge clk);
    begin
      logic [7:0] lat_seen [5];
      logic       lat_v [5];
      logic       dv2;
      in_valid = 1'b1; in_data = 8'h11; in_sof = 1'b1; in_eof = 1'b0;
      @(negedge clk); lat_v[0] = out_valid; lat_seen[0] = out_data;
      in_data = 8'h22; in_sof = 1'b0;
      @(negedge clk); lat_v[1] = out_valid; lat_seen[1] = out_data; dv2 = dec_valid;
      in_data = 8'h33; in_eof = 1'b1;
      @(negedge clk); lat_v[2] = out_valid; lat_seen[2] = out_data;
      in_valid = 1'b0; in_eof = 1'b0;
      @(negedge clk); lat_v[3] = out_valid; lat_seen[3] = out_data;
      @(negedge clk); lat_v[4] = out_valid; lat_seen[4] = out_data;
      chk(!lat_v[0], $sformatf("R8 first slot: actual valid=%0b expected 0", lat_v[0]));
      chk(lat_v[1] && lat_seen[1] == 8'h11 && dv2,
          $sformatf("R8 R9 byte0: actual v=%0b d=%02h dec=%0b expected 1 11 1", lat_v[1], lat_seen[1], dv2));
      chk(lat_v[2] && lat_seen[2] == 8'h22,
          $sformatf("R8 byte1: actual v=%0b d=%02h expected 1 22", lat_v[2], lat_seen[2]));
      chk(lat_v[3] && lat_seen[3] == 8'h33,
          $sformatf("R8 last byte: actual v=%0b d=%02h expected 1 33", lat_v[3], lat_seen[3]));
      chk(!lat_v[4], $sformatf("R8 after frame: actual valid=%0b expected 0", lat_v[4]));
    end
    repeat (2) @(negedge clk);

    // R1: filtering off, every first-byte value, short and long frames
    for (int v = 0; v < 256; v++) begin
      run_frame(8'(v), 8'(v ^ 8'h3C), 8'h5A, 3);
      if (v < 16) run_frame(8'(v), 8'h00, 8'h00, 1);
    end

    // R2..R6: sweep of first byte over all values, per-byte enables, seven-bit mode,
    // and a second byte that matches, misses by one bit, is an all-call, or is zero
    cfg_filter_en = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int e0 = 0; e0 < 2; e0++)
        for (int e1 = 0; e1 < 2; e1++)
          for (int k = 0; k < 4; k++) begin
            logic [7:0] b1v;
            cfg_seven_bit = s[0];
            cfg_addr0 = {7'b1010010, e0[0]};
            cfg_addr1 = {7'h33, e1[0]};
            case (k)
              0: b1v = 8'h66;
              1: b1v = 8'h64;
              2: b1v = 8'hFE;
              default: b1v = 8'h00;
            endcase
            for (int v = 0; v < 256; v++) run_frame(8'(v), b1v, 8'(v ^ 8'hA5), 3);
          end

    // R10 and one-byte frames: frames ending on the first byte
    cfg_addr0 = 8'hA5; cfg_addr1 = 8'h67;
    for (int s = 0; s < 2; s++) begin
      cfg_seven_bit = s[0];
      for (int v = 0; v < 256; v++) run_frame(8'(v), 8'h00, 8'h00, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule